// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and takes care of bringing the machine out of reset and of entering the maskable (IRQ) and non-maskable (NMI) interrupt handlers. It holds the program counter, the stack pointer, the status byte and the Z and B registers, but only as far as reset and interrupt entry touch them. The core can overwrite the program counter and the status byte through two load ports while the sequencer is idle. The core tells the sequencer where it is in the instruction stream with two strobes: one just before an opcode fetch and one just after an instruction completes. A third input marks an instruction that has just cleared the interrupt mask.

On an entry the sequencer takes over a byte-wide synchronous memory port. It pushes the return address and the status onto the stack in page one and then reads the handler address from a vector pair. While it works, `busy` is high. On the final cycle `entry_done` pulses, and `entry_cost` gives the number of cycles the core should charge for the entry. A reset runs the same vector fetch, from the reset vector and without any pushes.

The status byte uses this bit map: bit 7 N, bit 6 V, bit 5 E (emulation), bit 4 B, bit 3 D, bit 2 I (mask), bit 1 Z, bit 0 C. The memory port returns read data one cycle after `mem_re`.

Top module: `intr_entry_seq`

## Requirements
- R1: While `rst` is high and during the vector fetch that follows it, `busy` is 1. The program counter low byte is read from the reset vector address (default 0xFFFC), then the high byte from that address plus one.
- R2: After reset completes, `sp_q` is 0x01FF, `z_q` and `b_q` are 0, and `stat_q` is 0x36 (only E, B, I and Z set).
- R3: Every push writes to address 0x0100 plus the stack pointer low byte, which then drops by one. The upper byte of `sp_q` stays 0x01.
- R4: A pending IRQ found at a boundary check is cleared whether or not it is taken. It causes an entry only when status bit 2 (I) is 0.
- R5: An entry pushes three bytes, in this order: PC[15:8], PC[7:0], then the status byte with bit 4 (B) forced to 0.
- R6: After an entry, status bit 3 (D) is 0 and bit 2 (I) is 1. The PC is loaded low byte first from the NMI vector (default 0xFFFA/0xFFFB) or the IRQ vector (default 0xFFFE/0xFFFF).
- R7: `entry_done` pulses for one cycle at the end of every entry sequence. `entry_cost` reads 7 with it for an interrupt entry and 0 for the end of a reset.
- R8: A pending IRQ is checked at both `pre_fetch` and `post_insn`. If `post_insn` comes with `ie_restored` high, the IRQ is not taken there. Instead the pending flag is set to the current level of `irq_line`, so that it is served at the next `pre_fetch`.
- R9: NMI is taken only when `nmi_line` changes from 0 to 1. A line that stays at 1 causes no further entry.
- R10: When an NMI request and a pending IRQ meet at the same boundary, the NMI is served first. The IRQ stays pending, and the I bit set by the NMI entry then masks it at the next check.
- R11: A rising edge on `irq_line` sets the pending flag. While `busy` is high, boundary strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | 1 | Maskable interrupt line, active high |
| nmi_line | input | 1 | Non-maskable interrupt line, active high |
| pre_fetch | input | 1 | Core is about to fetch an opcode |
| post_insn | input | 1 | Core has just completed an instruction |
| ie_restored | input | 1 | With post_insn: the completed instruction cleared the I bit |
| ld_pc | input | 1 | Load pc_d into the program counter (idle only) |
| pc_d | input | 16 | Program counter value from the core |
| ld_stat | input | 1 | Load stat_d into the status byte (idle only) |
| stat_d | input | 8 | Status value from the core |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_re |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| stat_q | output | 8 | Status byte |
| z_q | output | 8 | Z index register |
| b_q | output | 8 | Base-page register |
| busy | output | 1 | A reset or entry sequence is running |
| entry_done | output | 1 | Last cycle of a sequence |
| entry_cost | output | 4 | Cycle charge, valid with entry_done |

## Verification
A boundary strobe that is sampled at a clock edge raises `busy` in the very next cycle. An interrupt entry then keeps `busy` high for six cycles: three push cycles and three vector cycles. The new PC, SP and status are visible once `busy` falls. The bench drives every stimulus on the falling edge and samples one falling edge after the strobe to see whether an entry started. It then waits for `busy` to fall before it compares registers, and it compares the push and done records, which are captured on the rising edges when `mem_we` or `entry_done` is high. A reset occupies three vector cycles after `rst` falls. The bench reads the reset results only after that window, so that the one-cycle read latency of the memory model is counted.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    localparam int AW      = 16;
    localparam int DW      = 8;
    localparam int COST_W  = 4;

    // status bit positions
    localparam int FLG_N = 7;
    localparam int FLG_V = 6;
    localparam int FLG_E = 5;
    localparam int FLG_B = 4;
    localparam int FLG_D = 3;
    localparam int FLG_I = 2;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;

    localparam logic [DW-1:0] STAT_AT_RESET =
        DW'((1 << FLG_E) | (1 << FLG_B) | (1 << FLG_I) | (1 << FLG_Z));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_VEC_END
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_RESET,
        SRC_IRQ,
        SRC_NMI
    } entry_src_t;

    function automatic logic [DW-1:0] stacked_status(input logic [DW-1:0] s);
        logic [DW-1:0] r;
        r        = s;
        r[FLG_B] = 1'b0;
        return r;
    endfunction

    function automatic logic [DW-1:0] entered_status(input logic [DW-1:0] s);
        logic [DW-1:0] r;
        r        = s;
        r[FLG_D] = 1'b0;
        r[FLG_I] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ies_arbiter.sv
module ies_arbiter
    import intr_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_line,
    input  logic       nmi_line,
    input  logic       pre_fetch,
    input  logic       post_insn,
    input  logic       ie_restored,
    input  logic       idle,
    input  logic       i_mask,
    output logic       start,
    output entry_src_t start_src
);

    logic irq_last, nmi_last;
    logic irq_pend, nmi_req;
    logic irq_rise, nmi_rise;
    logic boundary;
    logic take_nmi, take_irq;
    logic pend_nxt;

    assign irq_rise = irq_line & ~irq_last;
    assign nmi_rise = nmi_line & ~nmi_last;
    assign boundary = idle & (pre_fetch | post_insn);

    always_comb begin
        take_nmi = 1'b0;
        take_irq = 1'b0;
        pend_nxt = irq_pend;
        if (boundary) begin
            if (nmi_req) begin
                take_nmi = 1'b1;
            end else if (post_insn && ie_restored) begin
                pend_nxt = irq_line;
            end else if (irq_pend) begin
                pend_nxt = 1'b0;
                take_irq = ~i_mask;
            end
        end
        if (irq_rise) begin
            pend_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_last <= 1'b0;
            nmi_last <= 1'b0;
            irq_pend <= 1'b0;
            nmi_req  <= 1'b0;
        end else begin
            irq_last <= irq_line;
            nmi_last <= nmi_line;
            irq_pend <= pend_nxt;
            nmi_req  <= nmi_rise | (nmi_req & ~take_nmi);
        end
    end

    assign start     = take_nmi | take_irq;
    assign start_src = take_nmi ? SRC_NMI : SRC_IRQ;

endmodule

// File: rtl/ies_sequencer.sv
module ies_sequencer
    import intr_entry_pkg::*;
#(
    parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
    parameter logic [AW-1:0] VEC_RST    = 16'hFFFC,
    parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE,
    parameter logic [7:0]    STACK_PAGE = 8'h01,
    parameter int            ENTRY_COST = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  entry_src_t        start_src,
    input  logic              ld_pc,
    input  logic [AW-1:0]     pc_d,
    input  logic              ld_stat,
    input  logic [DW-1:0]     stat_d,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     pc_q,
    output logic [AW-1:0]     sp_q,
    output logic [DW-1:0]     stat_q,
    output logic [DW-1:0]     z_q,
    output logic [DW-1:0]     b_q,
    output logic              busy,
    output logic              done,
    output logic [COST_W-1:0] cost
);

    localparam int SPL_W = AW - 8;

    seq_state_t      st;
    entry_src_t      src;
    logic [AW-1:0]   pc;
    logic [SPL_W-1:0] sp_lo;
    logic [DW-1:0]   stat, zr, br;
    logic [AW-1:0]   vec_base;
    logic            pushing;

    always_comb begin
        case (src)
            SRC_NMI: vec_base = VEC_NMI;
            SRC_IRQ: vec_base = VEC_IRQ;
            default: vec_base = VEC_RST;
        endcase
    end

    assign pushing = (st == ST_PUSH_HI) || (st == ST_PUSH_LO) || (st == ST_PUSH_ST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_VEC_LO;
            src   <= SRC_RESET;
            pc    <= '0;
            sp_lo <= '1;
            stat  <= STAT_AT_RESET;
            zr    <= '0;
            br    <= '0;
        end else begin
            if (pushing) begin
                sp_lo <= sp_lo - 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_PUSH_HI;
                        src <= start_src;
                    end else begin
                        if (ld_pc)   pc   <= pc_d;
                        if (ld_stat) stat <= stat_d;
                    end
                end
                ST_PUSH_HI: st <= ST_PUSH_LO;
                ST_PUSH_LO: st <= ST_PUSH_ST;
                ST_PUSH_ST: begin
                    stat <= entered_status(stat);
                    st   <= ST_VEC_LO;
                end
                ST_VEC_LO: st <= ST_VEC_HI;
                ST_VEC_HI: begin
                    pc[7:0] <= mem_rdata;
                    st      <= ST_VEC_END;
                end
                ST_VEC_END: begin
                    pc[AW-1:8] <= mem_rdata;
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = pushing;
        mem_wdata = '0;
        case (st)
            ST_PUSH_HI: begin
                mem_addr  = {STACK_PAGE, sp_lo};
                mem_wdata = pc[AW-1:8];
            end
            ST_PUSH_LO: begin
                mem_addr  = {STACK_PAGE, sp_lo};
                mem_wdata = pc[7:0];
            end
            ST_PUSH_ST: begin
                mem_addr  = {STACK_PAGE, sp_lo};
                mem_wdata = stacked_status(stat);
            end
            ST_VEC_LO: begin
                mem_addr = vec_base;
                mem_re   = 1'b1;
            end
            ST_VEC_HI: begin
                mem_addr = vec_base + 1'b1;
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end

    assign pc_q   = pc;
    assign sp_q   = {STACK_PAGE, sp_lo};
    assign stat_q = stat;
    assign z_q    = zr;
    assign b_q    = br;
    assign busy   = (st != ST_IDLE);
    assign done   = (st == ST_VEC_END);
    assign cost   = (done && src != SRC_RESET) ? COST_W'(ENTRY_COST) : '0;

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter logic [15:0] VEC_NMI    = 16'hFFFA,
    parameter logic [15:0] VEC_RST    = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter int          ENTRY_COST = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_line,
    input  logic        nmi_line,
    input  logic        pre_fetch,
    input  logic        post_insn,
    input  logic        ie_restored,
    input  logic        ld_pc,
    input  logic [15:0] pc_d,
    input  logic        ld_stat,
    input  logic [7:0]  stat_d,
    output logic [15:0] mem_addr,
    output logic        mem_re,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pc_q,
    output logic [15:0] sp_q,
    output logic [7:0]  stat_q,
    output logic [7:0]  z_q,
    output logic [7:0]  b_q,
    output logic        busy,
    output logic        entry_done,
    output logic [3:0]  entry_cost
);

    logic       start;
    entry_src_t start_src;

    ies_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .irq_line    (irq_line),
        .nmi_line    (nmi_line),
        .pre_fetch   (pre_fetch),
        .post_insn   (post_insn),
        .ie_restored (ie_restored),
        .idle        (~busy),
        .i_mask      (stat_q[FLG_I]),
        .start       (start),
        .start_src   (start_src)
    );

    ies_sequencer #(
        .VEC_NMI    (VEC_NMI),
        .VEC_RST    (VEC_RST),
        .VEC_IRQ    (VEC_IRQ),
        .STACK_PAGE (STACK_PAGE),
        .ENTRY_COST (ENTRY_COST)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_src (start_src),
        .ld_pc     (ld_pc),
        .pc_d      (pc_d),
        .ld_stat   (ld_stat),
        .stat_d    (stat_d),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pc_q      (pc_q),
        .sp_q      (sp_q),
        .stat_q    (stat_q),
        .z_q       (z_q),
        .b_q       (b_q),
        .busy      (busy),
        .done      (entry_done),
        .cost      (entry_cost)
    );

endmodule

// File: rtl/ies_chk.sv
module ies_chk (
    input logic        clk,
    input logic        rst,
    input logic        pre_fetch,
    input logic        post_insn,
    input logic [15:0] mem_addr,
    input logic        mem_re,
    input logic        mem_we,
    input logic [7:0]  mem_wdata,
    input logic [15:0] pc_q,
    input logic [15:0] sp_q,
    input logic [7:0]  stat_q,
    input logic [7:0]  z_q,
    input logic [7:0]  b_q,
    input logic        busy,
    input logic        entry_done,
    input logic [3:0]  entry_cost
);

    // R2
    reset_values_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sp_q == 16'h01FF && z_q == 8'h00 && b_q == 8'h00 && stat_q == 8'h36));

    // R3
    stack_page_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[15:8] == 8'h01 && mem_addr == sp_q));

    // R3
    sp_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_q[7:0] == $past(sp_q[7:0]) - 8'd1));

    // R5
    first_push_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> (mem_wdata == pc_q[15:8]));

    // R5
    second_push_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> (mem_we && mem_wdata == $past(pc_q[7:0])));

    // R6
    mask_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_done && entry_cost != 4'd0) |-> (stat_q[2] && !stat_q[3]));

    // R7
    cost_value_chk: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (entry_cost == 4'd7 || entry_cost == 4'd0));

    // R11
    strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pre_fetch || post_insn));

    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

endmodule

bind intr_entry_seq ies_chk u_ies_chk (
    .clk        (clk),
    .rst        (rst),
    .pre_fetch  (pre_fetch),
    .post_insn  (post_insn),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .pc_q       (pc_q),
    .sp_q       (sp_q),
    .stat_q     (stat_q),
    .z_q        (z_q),
    .b_q        (b_q),
    .busy       (busy),
    .entry_done (entry_done),
    .entry_cost (entry_cost)
);

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_line = 1'b0, nmi_line = 1'b0;
    logic        pre_fetch = 1'b0, post_insn = 1'b0, ie_restored = 1'b0;
    logic        ld_pc = 1'b0, ld_stat = 1'b0;
    logic [15:0] pc_d = '0;
    logic [7:0]  stat_d = '0;
    logic [15:0] mem_addr, pc_q, sp_q;
    logic        mem_re, mem_we, busy, entry_done;
    logic [7:0]  mem_wdata, stat_q, z_q, b_q;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  entry_cost;

    int n_chk = 0, n_bad = 0;
    int n_push = 0, n_done = 0;
    logic [15:0] log_a [64];
    logic [7:0]  log_d [64];
    logic [3:0]  last_cost = '0;
    bit          finished = 0;

    always #4 clk = ~clk;

    intr_entry_seq i_intr_entry_seq (.*);

    function automatic logic [7:0] vec_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'hC0;
            16'hFFFE: return 8'h78;
            16'hFFFF: return 8'h56;
            default:  return 8'hEE;
        endcase
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= vec_byte(mem_addr);
        if (mem_we) begin
            log_a[n_push[5:0]] <= mem_addr;
            log_d[n_push[5:0]] <= mem_wdata;
            n_push <= n_push + 1;
        end
        if (entry_done) begin
            last_cost <= entry_cost;
            n_done    <= n_done + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    endtask

    task automatic set_pc(input logic [15:0] v);
        @(negedge clk); ld_pc = 1'b1; pc_d = v;
        @(negedge clk); ld_pc = 1'b0;
    endtask

    task automatic set_stat(input logic [7:0] v);
        @(negedge clk); ld_stat = 1'b1; stat_d = v;
        @(negedge clk); ld_stat = 1'b0;
    endtask

    task automatic strobe_pre();
        @(negedge clk); pre_fetch = 1'b1;
        @(negedge clk); pre_fetch = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 1);
        wait_idle();
        check("R1 pc from reset vector", pc_q, 16'hC000);
        check("R2 sp", sp_q, 16'h01FF);
        check("R2 status", stat_q, 8'h36);
        check("R2 z", z_q, 0);
        check("R2 b", b_q, 0);
        check("R7 reset done count", n_done, 1);
        check("R7 reset cost", last_cost, 0);
    endtask

    task automatic t_irq_masked();
        @(negedge clk); irq_line = 1'b1;
        @(negedge clk); irq_line = 1'b0;
        strobe_pre();
        check("R4 masked irq not taken", busy, 0);
        set_stat(8'h30);
        strobe_pre();
        check("R4 pending cleared by masked check", busy, 0);
        check("R4 pc unchanged", pc_q, 16'hC000);
    endtask

    task automatic t_irq_taken();
        int base;
        set_pc(16'hA1B2);
        set_stat(8'hD9);
        @(negedge clk); irq_line = 1'b1;
        base = n_push;
        strobe_pre();
        check("R11 irq entry started", busy, 1);
        wait_idle();
        check("R5 push count", n_push - base, 3);
        check("R3 push addr 0", log_a[base[5:0]], 16'h01FF);
        check("R5 push data hi", log_d[base[5:0]], 8'hA1);
        check("R3 push addr 1", log_a[6'(base + 1)], 16'h01FE);
        check("R5 push data lo", log_d[6'(base + 1)], 8'hB2);
        check("R3 push addr 2", log_a[6'(base + 2)], 16'h01FD);
        check("R5 pushed status B cleared", log_d[6'(base + 2)], 8'hC9);
        check("R3 sp after entry", sp_q, 16'h01FC);
        check("R6 pc from irq vector", pc_q, 16'h5678);
        check("R6 status after entry", stat_q, 8'hD5);
        check("R7 irq cost", last_cost, 7);
        @(negedge clk); irq_line = 1'b0;
    endtask

    task automatic t_post_take();
        set_pc(16'h1111);
        set_stat(8'h00);
        @(negedge clk); irq_line = 1'b1;
        @(negedge clk); post_insn = 1'b1;
        @(negedge clk); post_insn = 1'b0;
        check("R8 irq taken at post_insn", busy, 1);
        wait_idle();
        check("R8 pc after post_insn entry", pc_q, 16'h5678);
        check("R3 sp continues down", sp_q, 16'h01F9);
        @(negedge clk); irq_line = 1'b0;
    endtask

    task automatic t_deferral();
        set_stat(8'h04);
        set_pc(16'h3333);
        @(negedge clk); irq_line = 1'b1;
        @(negedge clk); ld_stat = 1'b1; stat_d = 8'h00; post_insn = 1'b1; ie_restored = 1'b1;
        @(negedge clk); ld_stat = 1'b0; post_insn = 1'b0; ie_restored = 1'b0;
        check("R8 deferred at re-enable", busy, 0);
        strobe_pre();
        check("R8 taken at next pre_fetch", busy, 1);
        wait_idle();
        check("R8 pc after deferred entry", pc_q, 16'h5678);
        @(negedge clk); irq_line = 1'b0;
        set_stat(8'h04);
        @(negedge clk); irq_line = 1'b1;
        @(negedge clk); irq_line = 1'b0;
        @(negedge clk); ld_stat = 1'b1; stat_d = 8'h00; post_insn = 1'b1; ie_restored = 1'b1;
        @(negedge clk); ld_stat = 1'b0; post_insn = 1'b0; ie_restored = 1'b0;
        strobe_pre();
        check("R8 dropped line not re-armed", busy, 0);
    endtask

    task automatic t_nmi();
        set_pc(16'h2222);
        @(negedge clk); nmi_line = 1'b1;
        strobe_pre();
        check("R9 nmi entry on edge", busy, 1);
        wait_idle();
        check("R6 pc from nmi vector", pc_q, 16'h1234);
        check("R7 nmi cost", last_cost, 7);
        set_pc(16'h2223);
        strobe_pre();
        check("R9 held nmi no second entry", busy, 0);
        check("R9 pc kept", pc_q, 16'h2223);
        @(negedge clk); nmi_line = 1'b0;
        @(negedge clk); nmi_line = 1'b1;
        strobe_pre();
        check("R9 new edge taken under mask", busy, 1);
        wait_idle();
        @(negedge clk); nmi_line = 1'b0;
    endtask

    task automatic t_both();
        set_pc(16'h4444);
        set_stat(8'h00);
        @(negedge clk); irq_line = 1'b1; nmi_line = 1'b1;
        strobe_pre();
        wait_idle();
        check("R10 nmi served first", pc_q, 16'h1234);
        strobe_pre();
        check("R10 irq masked after nmi", busy, 0);
        check("R10 pc stays", pc_q, 16'h1234);
        @(negedge clk); irq_line = 1'b0; nmi_line = 1'b0;
    endtask

    initial begin
        t_reset();
        t_irq_masked();
        t_irq_taken();
        t_post_take();
        t_deferral();
        t_nmi();
        t_both();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule